// File: doc/BRIEF.md
# Address-Range Cache Maintenance Engine

This block takes a physical address range and a maintenance operation from software, then walks the range one 64-byte line at a time. For each line it sends a request to the cache side. Each request carries the line base address and a 2-bit operation code, and it moves under a valid/ready handshake.

Software sets it up through three 64-bit registers:
- a range-start register at byte offset 0x00;
- a range-end register at byte offset 0x08. The end address is exclusive, so it equals start plus byte count;
- a control register at byte offset 0x10.

A write to the control register launches the walk when the engine is idle. Software then polls the control register until its low bit reads zero.

The start address is rounded down to a line boundary. The walk stops at the first line base that is at or above the end address. A range that is empty, a range that is inverted and a reserved operation code all finish at once, with no traffic on the cache side.

Top module: `cmo_range_engine`

## Requirements
- R1: After reset, req_valid is 0 and the range-start, range-end and control registers all read as zero.
- R2: Registers sit at byte offsets 0x00 (range start), 0x08 (range end) and 0x10 (control). reg_rdata shows the selected register in the cycle after reg_rd is sampled. Any other offset reads as zero, and writes to it change nothing.
- R3: Only address bits 39:0 of a write to the start or end register are stored. Bits 63:40 are dropped and read back as zero.
- R4: Control bits 2:1 hold the operation code and bit 0 is the busy flag. A control write while idle stores the code and launches a walk, whatever its bit 0 holds. Read-back shows the stored code in bits 2:1.
- R5: req_op carries the stored code: 0 = write back then invalidate, 1 = invalidate with no write-back, 2 = write back and keep the line valid.
- R6: The first request address is the range start with bits 5:0 cleared. Each later request is 0x40 above the one before, and every request address has bits 5:0 equal to zero.
- R7: A walk issues exactly ceil((end − aligned_start)/64) requests. It stops after the last line base that is below the exclusive end address, and this holds up to the top of the 40-bit space.
- R8: If the aligned start is not below the end, or the code is 3, no request is issued and busy reads 0 in the cycle after the control write.
- R9: A walk that issues requests raises req_valid and busy at the control-write edge. Both fall at the edge that accepts the last request, after which control bit 0 reads 0.
- R10: While req_valid is high and req_ready is low, req_addr and req_op hold steady. After an accepted request, the next line appears in the following cycle with no idle cycle between.
- R11: While busy, writes to all three registers are ignored. The running walk and the stored start, end and code are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_ofs | input | 5 | Register byte offset |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data, registered |
| req_valid | output | 1 | Line maintenance request valid |
| req_ready | input | 1 | Cache side accepts the request |
| req_addr | output | 40 | Line base address |
| req_op | output | 2 | Maintenance operation code |

## Verification
- Read data is due one cycle after the read strobe, so the bench samples it at the next falling edge.
- A control write is seen at the next rising edge, and req_valid, req_addr and busy already reflect it at the falling edge that follows. The bench checks the first line there.
- An accepted request is replaced by the next line, or by a low req_valid, at the very next falling edge. The bench tracks its expected address and count per cycle and compares them at each falling edge, both with ready held high and with ready toggling.
- The busy flag is read once with ready held low right after launch, and once after req_valid has fallen. Each read is taken one cycle after its strobe.

// File: rtl/cre_pkg.sv
package cre_pkg;
  typedef enum logic [1:0] {
    OP_CLEAN_INV    = 2'd0,
    OP_INV_ONLY     = 2'd1,
    OP_CLEAN_SHARED = 2'd2,
    OP_RESERVED     = 2'd3
  } cmo_op_e;

  localparam int OFS_W = 5;
  localparam logic [OFS_W-1:0] OFS_START = 5'h00;
  localparam logic [OFS_W-1:0] OFS_END   = 5'h08;
  localparam logic [OFS_W-1:0] OFS_CTL   = 5'h10;
endpackage

// File: rtl/cre_regfile.sv
module cre_regfile
  import cre_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              rd,
  input  logic [OFS_W-1:0]  ofs,
  input  logic [DATA_W-1:0] wdata,
  input  logic              busy,
  output logic [ADDR_W-1:0] start_q,
  output logic [ADDR_W-1:0] end_q,
  output logic [1:0]        mode_q,
  output logic              launch,
  output logic [1:0]        launch_mode,
  output logic [DATA_W-1:0] rdata
);
  localparam int PAD_W = DATA_W - ADDR_W;
  localparam int CTL_PAD_W = DATA_W - 3;

  logic wr_ok;
  logic unused_wdata;

  assign wr_ok        = wr && !busy;
  assign launch       = wr_ok && (ofs == OFS_CTL);
  assign launch_mode  = wdata[2:1];
  assign unused_wdata = ^{wdata[DATA_W-1:ADDR_W], wdata[0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
      end_q   <= '0;
      mode_q  <= 2'd0;
    end else if (wr_ok) begin
      case (ofs)
        OFS_START: start_q <= wdata[ADDR_W-1:0];
        OFS_END:   end_q   <= wdata[ADDR_W-1:0];
        OFS_CTL:   mode_q  <= wdata[2:1];
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd) begin
      case (ofs)
        OFS_START: rdata <= {{PAD_W{1'b0}}, start_q};
        OFS_END:   rdata <= {{PAD_W{1'b0}}, end_q};
        OFS_CTL:   rdata <= {{CTL_PAD_W{1'b0}}, mode_q, busy};
        default:   rdata <= '0;
      endcase
    end
  end

  AST_FROZEN_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(start_q) && $stable(end_q) && $stable(mode_q))) else $error("frozen"); // R11
  AST_RDATA_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    rd && (ofs != OFS_CTL) |=> rdata[DATA_W-1:ADDR_W] == '0) else $error("upper"); // R3
endmodule

// File: rtl/cre_line_align.sv
module cre_line_align #(
  parameter int ADDR_W     = 40,
  parameter int LINE_BYTES = 64
) (
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [ADDR_W-1:0] end_addr,
  input  logic [1:0]        mode,
  output logic [ADDR_W-1:0] first_line,
  output logic              has_work
);
  localparam logic [ADDR_W-1:0] LINE_MASK = ADDR_W'(LINE_BYTES - 1);

  assign first_line = start_addr & ~LINE_MASK;
  assign has_work   = (mode != 2'd3) && (first_line < end_addr);
endmodule

// File: rtl/cre_walker.sv
module cre_walker #(
  parameter int ADDR_W     = 40,
  parameter int LINE_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              launch,
  input  logic [1:0]        launch_mode,
  input  logic [ADDR_W-1:0] first_line,
  input  logic              has_work,
  input  logic [ADDR_W-1:0] end_addr,
  input  logic              req_ready,
  output logic              busy,
  output logic              req_valid,
  output logic [ADDR_W-1:0] req_addr,
  output logic [1:0]        req_op
);
  localparam int LINE_SH = $clog2(LINE_BYTES);

  logic [ADDR_W:0] next_line;
  logic            last_line;

  assign next_line = {1'b0, req_addr} + (ADDR_W+1)'(LINE_BYTES);
  assign last_line = next_line >= {1'b0, end_addr};
  assign req_valid = busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      req_addr <= '0;
      req_op   <= 2'd0;
    end else if (launch && has_work) begin
      busy     <= 1'b1;
      req_addr <= first_line;
      req_op   <= launch_mode;
    end else if (busy && req_ready) begin
      if (last_line) busy <= 1'b0;
      else           req_addr <= next_line[ADDR_W-1:0];
    end
  end

  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_op)) else $error("hold"); // R10
  AST_LINE_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> req_addr[LINE_SH-1:0] == '0) else $error("align"); // R6
  AST_BELOW_END: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> req_addr < end_addr) else $error("end"); // R7
  AST_LINE_STEP: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready |=> !req_valid || (req_addr == ADDR_W'($past(req_addr) + ADDR_W'(LINE_BYTES)))) else $error("step"); // R6
  AST_RESERVED_SILENT: assert property (@(posedge clk) disable iff (rst)
    launch && (launch_mode == 2'd3) |=> !req_valid) else $error("rsvd"); // R8
endmodule

// File: rtl/cmo_range_engine.sv
module cmo_range_engine
  import cre_pkg::*;
#(
  parameter int DATA_W     = 64,
  parameter int ADDR_W     = 40,
  parameter int LINE_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [OFS_W-1:0]  reg_ofs,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  output logic [1:0]        req_op
);
  logic [ADDR_W-1:0] start_q, end_q, first_line;
  logic [1:0]        mode_q, launch_mode;
  logic              launch, busy, has_work;

  cre_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .rd(reg_rd), .ofs(reg_ofs),
    .wdata(reg_wdata), .busy(busy), .start_q(start_q), .end_q(end_q),
    .mode_q(mode_q), .launch(launch), .launch_mode(launch_mode),
    .rdata(reg_rdata)
  );

  cre_line_align #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_align (
    .start_addr(start_q), .end_addr(end_q), .mode(launch_mode),
    .first_line(first_line), .has_work(has_work)
  );

  cre_walker #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_walk (
    .clk(clk), .rst(rst), .launch(launch), .launch_mode(launch_mode),
    .first_line(first_line), .has_work(has_work), .end_addr(end_q),
    .req_ready(req_ready), .busy(busy), .req_valid(req_valid),
    .req_addr(req_addr), .req_op(req_op)
  );

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk)
    rst |=> !req_valid) else $error("reset"); // R1
  AST_OP_MATCHES_MODE: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> req_op == mode_q) else $error("op"); // R5
endmodule

// File: tb/tb_cmo_range_engine.sv
module tb_cmo_range_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [4:0]  reg_ofs = '0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic        req_valid, req_ready = 1'b0;
  logic [39:0] req_addr;
  logic [1:0]  req_op;

  int vectors = 0;
  int miscompares = 0;

  always #2 clk = ~clk;

  cmo_range_engine dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_ofs(reg_ofs),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .req_op(req_op)
  );

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] ofs, input logic [63:0] d);
    reg_wr = 1'b1; reg_ofs = ofs; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] ofs, output logic [63:0] d);
    reg_rd = 1'b1; reg_ofs = ofs;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  function automatic int exp_count(input logic [63:0] s, input logic [63:0] e, input int mode);
    logic [63:0] a;
    a = {24'd0, s[39:6], 6'd0};
    if (mode == 3 || a >= {24'd0, e[39:0]}) return 0;
    return int'(({24'd0, e[39:0]} - a + 64'd63) / 64);
  endfunction

  task automatic run_op(input logic [63:0] s, input logic [63:0] e, input int mode, input int pat);
    logic [63:0] d;
    logic [63:0] ea;
    int n, idx, cyc;
    n = exp_count(s, e, mode);
    ea = {24'd0, s[39:6], 6'd0};
    wr(5'h00, s);
    wr(5'h08, e);
    req_ready = 1'b0;
    wr(5'h10, 64'(mode) << 1);
    check(n > 0 ? "R9 valid at launch" : "R8 no request", {63'd0, req_valid}, {63'd0, n > 0});
    rd(5'h10, d);
    check(n > 0 ? "R9 busy after launch" : "R8 busy clear", {63'd0, d[0]}, {63'd0, n > 0});
    check("R4 mode readback", {62'd0, d[2:1]}, 64'(mode));
    idx = 0; cyc = 0;
    while (req_valid && cyc < 2000) begin
      check("R6 line address", {24'd0, req_addr}, ea);
      check("R5 op code", {62'd0, req_op}, 64'(mode));
      req_ready = (pat == 0) ? 1'b1 : 1'(cyc % 2);
      @(negedge clk);
      if (req_ready) begin idx++; ea = ea + 64; end
      cyc++;
    end
    req_ready = 1'b0;
    check("R7 request count", 64'(idx), 64'(n));
    rd(5'h10, d);
    check("R9 busy cleared", {63'd0, d[0]}, 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [63:0] d;
    logic [63:0] lens [6];
    int offs [3];
    lens = '{64'd0, 64'd1, 64'd63, 64'd64, 64'd65, 64'd200};
    offs = '{0, 1, 63};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    check("R1 valid idle", {63'd0, req_valid}, 64'd0);
    rd(5'h00, d); check("R1 start zero", d, 64'd0);
    rd(5'h08, d); check("R1 end zero", d, 64'd0);
    rd(5'h10, d); check("R1 ctl zero", d, 64'd0);

    wr(5'h00, 64'hABCD_EF12_3456_7890);
    rd(5'h00, d); check("R3 start upper dropped", d, 64'h0000_0012_3456_7890);
    wr(5'h08, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(5'h08, d); check("R3 end upper dropped", d, 64'h0000_00FF_FFFF_FFFF);
    wr(5'h18, 64'h1234);
    rd(5'h18, d); check("R2 unmapped reads zero", d, 64'd0);
    rd(5'h00, d); check("R2 start unaffected", d, 64'h0000_0012_3456_7890);

    for (int m = 0; m < 4; m++)
      for (int o = 0; o < 3; o++)
        for (int l = 0; l < 6; l++)
          for (int p = 0; p < 2; p++)
            run_op(64'h1000 + 64'(offs[o]), 64'h1000 + 64'(offs[o]) + lens[l], m, p);

    run_op(64'h5000, 64'h4000, 0, 0);                         // R8 inverted
    run_op(64'h00FF_FFFF_FF90, 64'h00FF_FFFF_FFFF, 2, 1);     // R7 top of space
    run_op(64'h3030, 64'h3080, 1, 0);                         // R6 rounding

    // R11: writes during a walk are ignored
    wr(5'h00, 64'h2000);
    wr(5'h08, 64'h2100);
    req_ready = 1'b0;
    wr(5'h10, 64'd2);
    wr(5'h00, 64'h9999);
    wr(5'h08, 64'h5);
    wr(5'h10, 64'd4);
    begin
      int cnt;
      logic [63:0] ea;
      cnt = 0; ea = 64'h2000;
      while (req_valid && cnt < 100) begin
        check("R11 walk address", {24'd0, req_addr}, ea);
        check("R11 walk op", {62'd0, req_op}, 64'd1);
        req_ready = 1'b1;
        @(negedge clk);
        cnt++; ea = ea + 64;
      end
      req_ready = 1'b0;
      check("R11 walk count", 64'(cnt), 64'd4);
    end
    rd(5'h00, d); check("R11 start kept", d, 64'h2000);
    rd(5'h08, d); check("R11 end kept", d, 64'h2100);
    rd(5'h10, d); check("R11 mode kept", d, 64'd2);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule